// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent timer channels behind a plain 32-bit register port that has an address, a write strobe with write data, and a read strobe with read data. Each channel loads a 64-bit interval into a 64-bit count. It then counts that value down once per prescaled tick. When the count is spent, the channel either reloads and keeps going (periodic) or stops itself (one-shot). Every expiry latches a per-channel pending flag. Software clears a flag by writing a one to it, and a shared interrupt line is raised while any enabled flag is pending.

Software starts a channel in three steps. It writes the interval words, then writes the control word with the run bit and the load-now bit set. It picks the tick rate with a 3-bit divider select. Because the count runs downward, software that wants elapsed time inverts the value it reads. Stopping a channel is not instantaneous: the channel keeps counting for two more ticks after the run bit is cleared. Software must therefore wait a few ticks before it reprograms the channel.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` is low.
- R2: The register map is as follows. Interrupt enable is at 0x00 and pending status at 0x04, with bit n belonging to channel n. Channel n registers start at 0x10 + 0x20*n: control at +0x0, interval low/high words at +0x4/+0x8, and count low/high words at +0xC/+0x10. Interval and enable registers read back what was written. In control, bit 0 is run, bit 1 is load-now, bits 6:4 are divider select and bit 7 is one-shot. Control bits 3:1 read as 0. Writes to count registers are ignored, and unmapped addresses read 0.
- R3: A control write with bit 1 set copies the full 64-bit interval into the count in the same clock edge, whether or not the run bit is set. Bit 1 is not stored.
- R4: While running, the count decreases by exactly one per tick with borrow across the 64 bits. While stopped, it holds its value.
- R5: A divider select of s gives one tick every 2^s clocks. The tick phase restarts when the channel starts.
- R6: In periodic mode (bit 7 = 0), a tick that finds the count at 0 sets the channel's pending bit and reloads the interval, so the period is interval+1 ticks.
- R7: In one-shot mode (bit 7 = 1), a tick that finds the count at 0 sets the pending bit, clears the run bit and leaves the count at 0.
- R8: Writing 1 to a status bit clears that channel's pending flag. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly while some channel has both its pending bit and its enable bit set.
- R10: After a control write clears the run bit of a running channel, the count still decrements on that clock's tick and on two further ticks, then holds. An expiry in that window raises no flag.
- R11: `rd_data` is registered. It shows the addressed register as sampled on the clock edge where `rd_en` is high, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume one access per cycle, either a write or a read, and an address held stable while its strobe is high. They also assume that a control write landing on the same edge as a channel's expiry takes priority, so the one-shot and periodic-wrap properties exclude that edge. The directed stimulus applies every access for exactly one cycle, on the falling edge. It never writes control registers on an expiry edge, and it starts each channel only after any earlier stop window has fully drained.

// File: rtl/dtm_pkg.sv
// Package dtm_pkg
// Shared register map offsets and control-field positions for the dual
// down-counting timer. Assumes a byte-addressed 32-bit register space.
package dtm_pkg;
    localparam int unsigned PRE_W       = 3;
    localparam int unsigned IE_OFF      = 'h00;
    localparam int unsigned ST_OFF      = 'h04;
    localparam int unsigned CH_BASE     = 'h10;
    localparam int unsigned CH_STRIDE   = 'h20;
    localparam int unsigned OFF_CTRL    = 'h00;
    localparam int unsigned OFF_IVL_LO  = 'h04;
    localparam int unsigned OFF_IVL_HI  = 'h08;
    localparam int unsigned OFF_CNT_LO  = 'h0C;
    localparam int unsigned OFF_CNT_HI  = 'h10;
    localparam int unsigned RUN_BIT     = 0;
    localparam int unsigned LOAD_BIT    = 1;
    localparam int unsigned PRE_LSB     = 4;
    localparam int unsigned ONESHOT_BIT = PRE_LSB + PRE_W;
endpackage

// File: rtl/dtm_prescaler.sv
// Module dtm_prescaler
// Generates a one-cycle tick every 2^sel clocks while run is high.
// Assumes the phase counter may restart whenever run drops.
module dtm_prescaler #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // Select the low phase bits that must all be set for a tick.
    always_comb mask = ~({DIV_W{1'b1}} << sel);

    assign tick = run && ((phase_q & mask) == mask);

    // Advance the phase while running, restart it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) phase_q <= '0;
        else                phase_q <= phase_q + 1'b1;
    end

    // R5
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/dtm_chan.sv
// Module dtm_chan
// One timer channel: control fields, 64-bit interval, 64-bit down count,
// periodic reload or one-shot stop, and a two-tick drain after disable.
// Assumes at most one register write per cycle.
module dtm_chan
    import dtm_pkg::*;
#(
    parameter int unsigned DW           = 32,
    parameter int unsigned DRAIN_TICKS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_we,
    input  logic            ivl_lo_we,
    input  logic            ivl_hi_we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   ctrl_rd,
    output logic [2*DW-1:0] cnt,
    output logic            fire
);
    localparam int unsigned CNT_W = 2 * DW;
    localparam int unsigned DR_W  = $clog2(DRAIN_TICKS + 1);

    logic             run_q, os_q, tick, running;
    logic [PRE_W-1:0] sel_q;
    logic [CNT_W-1:0] ivl_q, cnt_q;
    logic [DR_W-1:0]  drain_q;
    logic             load_req;

    assign running  = run_q || (drain_q != '0);
    assign fire     = tick && run_q && (cnt_q == '0);
    assign load_req = ctrl_we && wdata[LOAD_BIT];
    assign cnt      = cnt_q;

    dtm_prescaler #(.SEL_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .sel   (sel_q),
        .tick  (tick)
    );

    // Assemble the control readback; the load bit is never stored.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[RUN_BIT]            = run_q;
        ctrl_rd[PRE_LSB +: PRE_W]   = sel_q;
        ctrl_rd[ONESHOT_BIT]        = os_q;
    end

    // Hold control fields, one-shot self-stop and the disable drain window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            os_q    <= 1'b0;
            sel_q   <= '0;
            drain_q <= '0;
        end else if (ctrl_we) begin
            run_q <= wdata[RUN_BIT];
            os_q  <= wdata[ONESHOT_BIT];
            sel_q <= wdata[PRE_LSB +: PRE_W];
            if (run_q && !wdata[RUN_BIT]) drain_q <= DR_W'(DRAIN_TICKS);
            else if (wdata[RUN_BIT])      drain_q <= '0;
        end else begin
            if (fire && os_q) run_q <= 1'b0;
            if (tick && !run_q && drain_q != '0) drain_q <= drain_q - 1'b1;
        end
    end

    // Capture the interval words.
    always_ff @(posedge clk) begin
        if (!rst_n) ivl_q <= '0;
        else if (ivl_lo_we) ivl_q[DW-1:0]     <= wdata;
        else if (ivl_hi_we) ivl_q[CNT_W-1:DW] <= wdata;
    end

    // Load, reload on expiry, or decrement the count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load_req)           cnt_q <= ivl_q;
        else if (fire)               cnt_q <= os_q ? cnt_q : ivl_q;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> cnt_q == $past(ivl_q));
    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !load_req) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load_req) |=> $stable(cnt_q));
    // R6
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !os_q && !ctrl_we) |=> cnt_q == $past(ivl_q));
    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && os_q && !ctrl_we) |=> (!run_q && cnt_q == '0));
    // R10
    drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && run_q && !wdata[RUN_BIT]) |=> drain_q == DR_W'(DRAIN_TICKS));
endmodule

// File: rtl/dual_down_timer.sv
// Module dual_down_timer
// Register decode, interrupt enable, write-one-to-clear status and the
// shared interrupt for NUM_CH down-counting channels.
// Assumes one access per cycle and addresses stable while strobed.
module dual_down_timer
    import dtm_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned DW          = 32,
    parameter int unsigned AW          = 8,
    parameter int unsigned DRAIN_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    logic [NUM_CH-1:0] ie_q, st_q, fire;
    logic [DW-1:0]     ctrl_rd [NUM_CH];
    logic [2*DW-1:0]   cnt_v   [NUM_CH];
    logic [DW-1:0]     rd_mux;
    logic              wr_ie, wr_st;

    assign wr_ie = wr_en && (addr == AW'(IE_OFF));
    assign wr_st = wr_en && (addr == AW'(ST_OFF));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int unsigned BASE = CH_BASE + g * CH_STRIDE;
        logic we_ctrl, we_lo, we_hi;
        assign we_ctrl = wr_en && (addr == AW'(BASE + OFF_CTRL));
        assign we_lo   = wr_en && (addr == AW'(BASE + OFF_IVL_LO));
        assign we_hi   = wr_en && (addr == AW'(BASE + OFF_IVL_HI));

        dtm_chan #(.DW(DW), .DRAIN_TICKS(DRAIN_TICKS)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_we   (we_ctrl),
            .ivl_lo_we (we_lo),
            .ivl_hi_we (we_hi),
            .wdata     (wdata),
            .ctrl_rd   (ctrl_rd[g]),
            .cnt       (cnt_v[g]),
            .fire      (fire[g])
        );

        // R6
        st_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[g] |=> st_q[g]);
        // R8
        st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_st && wdata[g] && !fire[g]) |=> !st_q[g]);
        // R9
        irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fire[g] && ie_q[g] && !wr_ie) |=> irq);
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (wr_ie) ie_q <= wdata[NUM_CH-1:0];
    end

    // Pending flags: expiry sets, a written one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~(wr_st ? wdata[NUM_CH-1:0] : '0)) | fire;
    end

    assign irq = |(st_q & ie_q);

    // Select the addressed register for a read.
    always_comb begin
        rd_mux = '0;
        if (addr == AW'(IE_OFF)) rd_mux[NUM_CH-1:0] = ie_q;
        if (addr == AW'(ST_OFF)) rd_mux[NUM_CH-1:0] = st_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == AW'(CH_BASE + n*CH_STRIDE + OFF_CTRL))   rd_mux = ctrl_rd[n];
            if (addr == AW'(CH_BASE + n*CH_STRIDE + OFF_CNT_LO)) rd_mux = cnt_v[n][DW-1:0];
            if (addr == AW'(CH_BASE + n*CH_STRIDE + OFF_CNT_HI)) rd_mux = cnt_v[n][2*DW-1:DW];
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == AW'(CH_BASE + n*CH_STRIDE + OFF_IVL_LO) ||
                addr == AW'(CH_BASE + n*CH_STRIDE + OFF_IVL_HI))
                rd_mux = ivl_word(n, addr == AW'(CH_BASE + n*CH_STRIDE + OFF_IVL_HI));
        end
    end

    // Interval readback comes from a shadow copy kept at the top level.
    logic [2*DW-1:0] ivl_sh [NUM_CH];

    function automatic logic [DW-1:0] ivl_word(input int n, input logic hi);
        return hi ? ivl_sh[n][2*DW-1:DW] : ivl_sh[n][DW-1:0];
    endfunction

    // Shadow the interval words for readback.
    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_CH; n++) begin
            if (!rst_n) ivl_sh[n] <= '0;
            else if (wr_en && addr == AW'(CH_BASE + n*CH_STRIDE + OFF_IVL_LO))
                ivl_sh[n][DW-1:0] <= wdata;
            else if (wr_en && addr == AW'(CH_BASE + n*CH_STRIDE + OFF_IVL_HI))
                ivl_sh[n][2*DW-1:DW] <= wdata;
        end
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R11
    rd_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(IE_OFF)) |=> rd_data[NUM_CH-1:0] == $past(ie_q));
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/dual_down_timer_bench.sv
`timescale 1ns/1ps
module dual_down_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_down_timer u_dual_down_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        do_rd(8'h00, v); chk("R1 ie", v, 0);
        do_rd(8'h04, v); chk("R1 st", v, 0);
        do_rd(8'h10, v); chk("R1 ctrl0", v, 0);
        do_rd(8'h3C, v); chk("R1 cnt1", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        do_wr(8'h14, 32'h1234_5678);
        do_wr(8'h18, 32'h9ABC_DEF0);
        do_rd(8'h14, v); chk("R2 ivl lo", v, 32'h1234_5678);
        do_rd(8'h18, v); chk("R2 ivl hi", v, 32'h9ABC_DEF0);
        do_wr(8'h10, 32'hFFFF_FFFE);
        do_rd(8'h10, v); chk("R2 ctrl fields", v, 32'h0000_00F0);
        do_rd(8'h1C, v); chk("R3 load lo", v, 32'h1234_5678);
        do_rd(8'h20, v); chk("R3 load hi", v, 32'h9ABC_DEF0);
        idle(5);
        do_wr(8'h1C, 32'h0);
        do_rd(8'h1C, v); chk("R2 cnt write ignored / R4 hold", v, 32'h1234_5678);
        do_wr(8'h08, 32'hFFFF_FFFF);
        do_rd(8'h08, v); chk("R2 unmapped", v, 0);
        do_wr(8'h00, 32'h3);
        do_rd(8'h00, v); chk("R2 ie rw", v, 32'h3);
        do_wr(8'h00, 32'h0);
        do_wr(8'h10, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        do_wr(8'h14, 32'd100); do_wr(8'h18, 32'd0);
        do_wr(8'h10, 32'h03);                  // edge P0
        do_rd(8'h1C, v); chk("R3 load on start", v, 32'd100);
        idle(10);
        do_rd(8'h1C, v); chk("R4 decrement", v, 32'd89);
        idle(3);
        chk("R11 hold between reads", rd_data, 32'd89);
        do_wr(8'h10, 32'h00);                  // stop: tick this edge + 2 more
        idle(10);
        do_rd(8'h1C, v); chk("R10 drain two ticks", v, 32'd82);
        idle(5);
        do_rd(8'h1C, v); chk("R4 hold stopped", v, 32'd82);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        do_wr(8'h14, 32'd100);
        do_wr(8'h10, 32'h23);                  // sel=2, edge P0
        idle(10);
        do_rd(8'h1C, v); chk("R5 divide by 4", v, 32'd98);
        do_wr(8'h10, 32'h00); idle(40);
        do_wr(8'h10, 32'h73);                  // sel=7, edge P0
        idle(300);
        do_rd(8'h1C, v); chk("R5 divide by 128", v, 32'd98);
        do_wr(8'h10, 32'h00); idle(400);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        do_wr(8'h34, 32'd3); do_wr(8'h38, 32'd0);
        do_wr(8'h10, 32'h00);
        do_wr(8'h30, 32'h03);                  // edge P0, fires at P4, P8
        do_rd(8'h04, v);                       // value after P0
        idle(1);
        do_rd(8'h04, v); chk("R6 not yet pending", v, 0);
        idle(2);
        do_rd(8'h04, v); chk("R6 pending after expiry", v, 32'h2);
        chk("R9 masked irq", irq, 0);
        do_rd(8'h3C, v); chk("R6 reloaded count", v, 32'd1);
        do_wr(8'h00, 32'h2);                   // edge P8
        chk("R9 irq enabled", irq, 1);
        do_wr(8'h04, 32'h1);
        chk("R8 zero bit leaves flag", irq, 1);
        do_wr(8'h04, 32'h2);
        chk("R8 w1c clears", irq, 0);
        do_wr(8'h30, 32'h00);                  // stop before next expiry at P12
        idle(10);
        do_rd(8'h04, v); chk("R10 no flag in drain", v, 0);
        chk("R9 irq low", irq, 0);
        do_wr(8'h00, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        do_wr(8'h14, 32'd5);
        do_wr(8'h10, 32'h83);
        idle(20);
        do_rd(8'h10, v); chk("R7 run cleared", v, 32'h80);
        do_rd(8'h1C, v); chk("R7 count stays 0", v, 0);
        do_rd(8'h04, v); chk("R7 pending set", v, 32'h1);
        do_wr(8'h04, 32'h1);
        do_rd(8'h04, v); chk("R8 cleared", v, 0);
        do_wr(8'h10, 32'h00);
    endtask

    task automatic t_wide;
        logic [31:0] v;
        do_wr(8'h14, 32'd0); do_wr(8'h18, 32'd1);
        do_wr(8'h10, 32'h03);                  // edge P0, count 2^32
        idle(4);
        do_rd(8'h20, v); chk("R4 borrow hi", v, 32'd0);
        do_rd(8'h1C, v); chk("R4 borrow lo", v, 32'hFFFF_FFFB);
        do_wr(8'h10, 32'h00);
        idle(5);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_prescale();
        t_periodic();
        t_oneshot();
        t_wide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule